// File: doc/BRIEF.md
# Rising-Edge Phase-Frequency Detector with Three-State Output

This block compares a reference signal against a feedback signal from an oscillator divider, looking only at the rising edges of each. Whichever input shows a rising edge first sets the output drive. A reference edge that arrives first drives the output high, and the drive holds until the next feedback edge. A feedback edge that arrives first drives the output low, and the drive holds until the next reference edge. The output then returns to high impedance. An external loop filter integrates this drive. When the loop is aligned, the output floats nearly all the time and gives only short correction pulses.

Both inputs are asynchronous. Each one is resynchronized to the system clock and then edge-detected, so a level change appears at the outputs a fixed number of clocks later. The three-state output is presented in two forms: a drive-enable and drive-value pair, and an optional three-state pad built from that pair. A lock flag is high while the output floats.

Top module: `pfd_tristate_det`

## Requirements
- R1: While `rst_ni` is low and after its release with no input edges, `drive_en_o` is 0 and `lock_o` is 1.
- R2: From the floating state, a lone reference rising edge sets `drive_en_o`=1 and `drive_val_o`=1. A later feedback rising edge returns the output to floating.
- R3: From the floating state, a lone feedback rising edge sets `drive_en_o`=1 and `drive_val_o`=0. A later reference rising edge returns the output to floating.
- R4: `lock_o` is 1 exactly when `drive_en_o` is 0.
- R5: When the reference and feedback rising edges are detected in the same clock, the result is floating with no drive pulse, whatever the prior state.
- R6: Further rising edges of the input that set the current drive keep that drive. For example, repeated feedback edges with no reference edge hold the output driven low.
- R7: Falling edges and the length of the high or low levels have no effect on the outputs.
- R8: An input rising edge applied just after a clock edge changes the outputs after the third following rising clock edge (SYNC_STAGES+1 clocks), and not earlier.
- R9: With PAD_EN=1, `pad_o` equals `drive_val_o` while `drive_en_o` is 1 and is high impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference signal, asynchronous |
| fb_i | input | 1 | Feedback signal, asynchronous |
| drive_en_o | output | 1 | Output is being driven |
| drive_val_o | output | 1 | Driven level (1 high, 0 low) |
| lock_o | output | 1 | High while the output floats |
| pad_o | output | 1 | Three-state pad: value when enabled, else Z |

## Verification
The assertions take for granted that each input holds a level for at least one full clock period, so that the synchronizer captures every rising edge as exactly one detection pulse. The stimulus keeps to this by changing the inputs only at falling clock edges and holding each level for one to five clocks. It leaves several clocks between edge events so that each event settles before the outputs are compared with a bench model that works from edge order. Directed cases place both edges in the same cycle and measure the exact latency.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PD_FLOAT = 2'd0,
    PD_UP    = 2'd1,
    PD_DN    = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sig_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R7
endmodule

// File: rtl/pfd_state.sv
module pfd_state
  import pfd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_ref_i,
  input  logic rise_fb_i,
  output logic drive_en_o,
  output logic drive_val_o,
  output logic lock_o
);
  pd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (rise_ref_i && rise_fb_i) begin
      state_d = PD_FLOAT;
    end else if (rise_ref_i) begin
      state_d = (state_q == PD_DN) ? PD_FLOAT : PD_UP;
    end else if (rise_fb_i) begin
      state_d = (state_q == PD_UP) ? PD_FLOAT : PD_DN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PD_FLOAT;
    else         state_q <= state_d;
  end

  assign drive_en_o  = (state_q != PD_FLOAT);
  assign drive_val_o = (state_q == PD_UP);
  assign lock_o      = (state_q == PD_FLOAT);

  AST_UP_ON_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PD_FLOAT && rise_ref_i && !rise_fb_i) |=> (drive_en_o && drive_val_o)); // R2
  AST_UP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PD_UP && rise_fb_i) |=> lock_o); // R2
  AST_DN_ON_FB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PD_FLOAT && rise_fb_i && !rise_ref_i) |=> (drive_en_o && !drive_val_o)); // R3
  AST_DN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PD_DN && rise_ref_i) |=> lock_o); // R3
  AST_BOTH_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_ref_i && rise_fb_i) |=> !drive_en_o); // R5
  AST_HOLD_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PD_UP && !rise_fb_i) |=> (drive_en_o && drive_val_o)); // R6
  AST_NO_EDGE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_ref_i && !rise_fb_i) |=> $stable(state_q)); // R7
endmodule

// File: rtl/pfd_tristate_det.sv
module pfd_tristate_det #(
  parameter int SYNC_STAGES = 2,
  parameter bit PAD_EN      = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  output logic drive_en_o,
  output logic drive_val_o,
  output logic lock_o,
  output wire  pad_o
);
  logic rise_ref, rise_fb;

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
    .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(ref_i), .rise_o(rise_ref)
  );

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_fb (
    .clk_i (clk_i), .rst_ni(rst_ni), .sig_i(fb_i), .rise_o(rise_fb)
  );

  pfd_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_ref_i (rise_ref),
    .rise_fb_i  (rise_fb),
    .drive_en_o (drive_en_o),
    .drive_val_o(drive_val_o),
    .lock_o     (lock_o)
  );

  generate
    if (PAD_EN) begin : g_pad
      assign pad_o = drive_en_o ? drive_val_o : 1'bz;
      AST_PAD_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_en_o |-> (pad_o === drive_val_o)); // R9
    end else begin : g_nopad
      assign pad_o = drive_val_o;
    end
  endgenerate

  AST_LOCK_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o != drive_en_o); // R4
endmodule

// File: tb/pfd_tristate_det_test.sv
module pfd_tristate_det_test;
  localparam int F = 0, U = 1, D = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_i = 1'b0;
  logic fb_i = 1'b0;
  logic drive_en, drive_val, lock;
  wire  pad;
  int   checks = 0;
  int   failures = 0;
  int   exp_st = F;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pfd_tristate_det uut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i), .fb_i(fb_i),
    .drive_en_o(drive_en), .drive_val_o(drive_val), .lock_o(lock), .pad_o(pad)
  );

  function automatic int next_st(int s, bit r, bit f);
    if (r && f) return F;
    if (r) return (s == D) ? F : U;
    if (f) return (s == U) ? F : D;
    return s;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_st(string req, int e);
    logic [2:0] act, exp;
    logic       exp_pad;
    act = {drive_en, drive_val, lock};
    exp = {e != F, e == U, e == F};
    exp_pad = (e == F) ? 1'bz : (e == U);
    checks++;
    if (act !== exp || pad !== exp_pad) begin
      failures++;
      $display("FAIL %s: en/val/lock/pad=%b%b actual, %b%b expected", req, act, pad, exp, exp_pad);
    end
  endtask

  // raise selected inputs, hold for w clocks, lower, let settle
  task automatic pulse(bit r, bit f, int w);
    ref_i = r; fb_i = f;
    tick(w);
    ref_i = 1'b0; fb_i = 1'b0;
    tick(4);
    exp_st = next_st(exp_st, r, f);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    tick(2);
    check_st("R1 in reset", F);
    rst_ni = 1'b1;
    tick(3);
    check_st("R1 after reset", F);

    // R8 exact latency
    ref_i = 1'b1;
    tick(2);
    check_st("R8 not before latency", F);
    tick(1);
    check_st("R8 at latency", U);
    ref_i = 1'b0; tick(3);
    exp_st = U;
    check_st("R7 falling ref ignored", U);
    pulse(1'b1, 1'b0, 3);
    check_st("R6 repeated ref holds high", U);
    pulse(1'b0, 1'b1, 2);
    check_st("R2 fb clears high", F);

    pulse(1'b0, 1'b1, 1);
    check_st("R3 fb first drives low", D);
    for (int i = 0; i < 3; i++) begin
      pulse(1'b0, 1'b1, 1 + i);
      check_st("R6 missing ref keeps low", D);
    end
    pulse(1'b1, 1'b0, 5);
    check_st("R3 ref clears low", F);

    pulse(1'b1, 1'b1, 2);
    check_st("R5 both from float", F);
    pulse(1'b1, 1'b0, 1);
    pulse(1'b1, 1'b1, 1);
    check_st("R5 both from high", F);
    pulse(1'b0, 1'b1, 4);
    pulse(1'b1, 1'b1, 3);
    check_st("R5 both from low", F);

    // R7 long level: ref held high many clocks, no extra effect
    ref_i = 1'b1; tick(20);
    exp_st = next_st(exp_st, 1'b1, 1'b0);
    check_st("R7 long high level", U);
    ref_i = 1'b0; tick(4);

    for (int i = 0; i < 150; i++) begin
      int op;
      op = $urandom_range(0, 3);
      pulse(op == 1 || op == 3, op == 2 || op == 3, $urandom_range(1, 5));
      check_st("R2/R3/R4/R5/R6 random", exp_st);
      checks++;
      if (lock !== !drive_en) begin
        failures++;
        $display("FAIL R4: lock=%b actual, %b expected", lock, !drive_en);
      end
    end
    finish_run();
  end
endmodule